// File: doc/BRIEF.md
# I2C Message List Sequencer

This block walks a list of I2C messages and turns it into the stream of byte-level commands that an I2C byte command controller executes. Each message is described by a 7-bit target address, a read flag, a flag that suppresses the repeated start in front of it, and a byte count. The sequencer sits between a descriptor source and the controller. Whenever the controller signals that its previous command has finished, the sequencer takes the controller's status and picks the next command. That command is a START carrying the address byte, a WRITE carrying the next outgoing byte, a READ with either an ACK or a NACK, a STOP, or an interrupt acknowledge.

Outgoing bytes come from a simple data port. The sequencer takes the byte shown on `wr_data_i` and pulses `wr_pop_o` to consume it. Each received byte leaves on `rd_data_o` with a one-cycle `rd_valid_o`. The descriptor source shows the current message and moves to the next entry when `desc_next_o` pulses. When the list is finished, or the transfer has been abandoned, the sequencer gives one `fin_o` pulse. `ok_o` tells a clean end from a failed one. A cycle watchdog, loaded through `wd_limit_i`, ends a transfer that stalls.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset `state_o` is 0 (the finished state), `busy_o` is 0, and neither `cmd_valid_o` nor `fin_o` is asserted.
- R2: A `go_i` pulse while idle produces, on the next cycle, one `cmd_valid_o` with code 0x91 (start). `cmd_data_o` carries the address in bits 7:1 and the read flag in bit 0. `state_o` becomes 1 and `busy_o` becomes 1. A `go_i` while busy adds no command.
- R3: When a completion event (`irq_i`) reports ACK after the address or a data byte of a write message with bytes left, the sequencer issues code 0x11 (write). `cmd_data_o` is the byte from `wr_data_i` and `wr_pop_o` pulses. `state_o` is 2.
- R4: In a read message, each read command is 0x21 (read, then ACK) except the one for the final byte, which is 0x29 (read, then NACK). `state_o` is 3. The `rx_data_i` of each completed read appears on `rd_data_o` with `rd_valid_o`, in order.
- R5: When a message ends and another follows, `desc_next_o` pulses and the next descriptor is used from two cycles later. That message gets a new start (0x91, `state_o` 1) with its own address byte, unless its no-start flag is set. With the flag set, its first write (0x11, `state_o` 2) or read (`state_o` 3) follows at once.
- R6: When the last message ends, the sequencer issues code 0x41 (stop) and `state_o` becomes 0. A message of length 0 ends as soon as its address is acknowledged.
- R7: A NACK reported after an address byte or a write byte produces a stop (0x41) and `state_o` 4, the error state.
- R8: Arbitration loss reported in any active state produces a stop (0x41) and `state_o` 4. It takes priority over NACK and over read data: no byte is delivered for that event.
- R9: A completion event that arrives in state 0 or 4 while busy produces code 0x01 (interrupt acknowledge), one `fin_o` pulse and a cleared `busy_o`. `ok_o` is 1 only when the state is 0.
- R10: With a nonzero `wd_limit_i`, a transfer still busy about `wd_limit_i` cycles after it started ends with `fin_o`, `timeout_o` 1, `ok_o` 0, `state_o` 4 and no further command. A limit of 0 disables the watchdog. A normal finish leaves `timeout_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start the message list from the descriptor shown |
| wd_limit_i | input | WD_W | Watchdog limit in cycles, 0 disables |
| desc_addr_i | input | 7 | Target address of the current message |
| desc_rd_i | input | 1 | Current message is a read |
| desc_nostart_i | input | 1 | Current message continues without a repeated start |
| desc_len_i | input | LEN_W | Byte count of the current message |
| desc_last_i | input | 1 | Current message is the last in the list |
| desc_next_o | output | 1 | Pulse: advance to the next descriptor |
| wr_data_i | input | 8 | Next outgoing data byte |
| wr_pop_o | output | 1 | Pulse: outgoing byte consumed |
| rd_valid_o | output | 1 | Pulse: received byte on rd_data_o |
| rd_data_o | output | 8 | Received data byte |
| cmd_valid_o | output | 1 | Pulse: command to the byte controller |
| cmd_code_o | output | 8 | Command code |
| cmd_data_o | output | 8 | Byte to load into the controller's data register |
| irq_i | input | 1 | Controller completion event |
| stat_nack_i | input | 1 | Target did not acknowledge the last byte |
| stat_arb_i | input | 1 | Arbitration lost |
| rx_data_i | input | 8 | Byte received by the controller |
| state_o | output | 3 | Sequencer state: 0 done, 1 start, 2 write, 3 read, 4 error |
| busy_o | output | 1 | A transfer is in progress |
| fin_o | output | 1 | Pulse: transfer finished |
| ok_o | output | 1 | Last transfer finished without error |
| timeout_o | output | 1 | Last transfer ended by the watchdog |

## Verification
The bench targets the choice of the final read NACK, both for a one-byte read and at the end of a multi-byte read. A design with an off-by-one here would acknowledge the last byte, or refuse one early, and the expected command code would not match. It also drives message boundaries with and without the no-start flag, a zero-length probe write, and a read that follows a write with no restart. A design that mishandles these emits a stray start, skips the stop, or uses the old descriptor's direction. Error cases put a NACK on the address and on a data byte, and arbitration loss on a read. A design that got these wrong would keep transferring, skip the stop, or hand out a byte it should drop. Finally, a controller that never answers must end through the watchdog, and a long but valid transfer must not time out when the limit is zero.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    ST_DONE  = 3'd0,
    ST_START = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_ERROR = 3'd4
  } seq_state_e;

  // internal step of the sequencer between controller events
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAITD = 2'd1,
    PH_NEWD  = 2'd2
  } seq_phase_e;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_START   = 8'h91;
  localparam logic [BYTE_W-1:0] CMD_STOP    = 8'h41;
  localparam logic [BYTE_W-1:0] CMD_WRITE   = 8'h11;
  localparam logic [BYTE_W-1:0] CMD_RD_ACK  = 8'h21;
  localparam logic [BYTE_W-1:0] CMD_RD_NACK = 8'h29;
  localparam logic [BYTE_W-1:0] CMD_IACK    = 8'h01;

  function automatic logic [BYTE_W-1:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

endpackage

// File: rtl/i2c_seq_wdog.sv
module i2c_seq_wdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  logic [WD_W-1:0] limit_i,
  output logic            expire_o
);

  localparam logic [WD_W-1:0] ONE = WD_W'(1);

  logic [WD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= (limit_i != '0) && (cnt_q == limit_i - ONE);
      if (cnt_q != '1) cnt_q <= cnt_q + ONE;
    end
  end

endmodule

// File: rtl/i2c_seq_core.sv
module i2c_seq_core
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              abort_i,
  input  logic [6:0]        desc_addr_i,
  input  logic              desc_rd_i,
  input  logic              desc_nostart_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic              desc_last_i,
  output logic              desc_next_o,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              wr_pop_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_code_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  input  logic              irq_i,
  input  logic              stat_nack_i,
  input  logic              stat_arb_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output seq_state_e        state_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic              ok_o,
  output logic              timeout_o
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  seq_state_e       state_q, n_state, t_st;
  seq_phase_e       ph_q, n_ph;
  logic [LEN_W-1:0] pos_q, n_pos, t_pos;
  logic             busy_q, n_busy;
  logic             n_cmd_v, n_fin, n_ok, n_to, n_rdv, n_pop, n_dnext;
  logic [BYTE_W-1:0] n_code, n_data, n_rdd;
  logic             do_tail, do_body;
  logic [LEN_W-1:0] last_idx;

  assign last_idx = desc_len_i - LEN_ONE;

  always_comb begin
    n_state = state_q;
    n_ph    = ph_q;
    n_pos   = pos_q;
    n_busy  = busy_q;
    n_cmd_v = 1'b0;
    n_code  = cmd_code_o;
    n_data  = cmd_data_o;
    n_fin   = 1'b0;
    n_ok    = ok_o;
    n_to    = timeout_o;
    n_rdv   = 1'b0;
    n_rdd   = rd_data_o;
    n_pop   = 1'b0;
    n_dnext = 1'b0;
    do_tail = 1'b0;
    do_body = 1'b0;
    t_st    = state_q;
    t_pos   = pos_q;

    if (abort_i && busy_q) begin
      // watchdog ends the transfer without touching the bus
      n_state = ST_ERROR;
      n_busy  = 1'b0;
      n_ph    = PH_IDLE;
      n_fin   = 1'b1;
      n_ok    = 1'b0;
      n_to    = 1'b1;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (!busy_q) begin
            if (go_i) begin
              n_busy  = 1'b1;
              n_pos   = '0;
              n_state = ST_START;
              n_cmd_v = 1'b1;
              n_code  = CMD_START;
              n_data  = addr_byte(desc_addr_i, desc_rd_i);
              n_to    = 1'b0;
            end
          end else if (irq_i) begin
            if (state_q == ST_DONE || state_q == ST_ERROR) begin
              n_cmd_v = 1'b1;
              n_code  = CMD_IACK;
              n_fin   = 1'b1;
              n_ok    = (state_q == ST_DONE);
              n_busy  = 1'b0;
            end else if (stat_arb_i) begin
              n_state = ST_ERROR;
              n_cmd_v = 1'b1;
              n_code  = CMD_STOP;
            end else if (state_q == ST_START || state_q == ST_WRITE) begin
              if (stat_nack_i) begin
                n_state = ST_ERROR;
                n_cmd_v = 1'b1;
                n_code  = CMD_STOP;
              end else begin
                t_st    = desc_rd_i ? ST_READ : ST_WRITE;
                t_pos   = pos_q;
                do_tail = 1'b1;
              end
            end else begin
              n_rdv   = 1'b1;
              n_rdd   = rx_data_i;
              t_st    = ST_READ;
              t_pos   = pos_q + LEN_ONE;
              do_tail = 1'b1;
            end
          end
        end
        PH_WAITD: n_ph = PH_NEWD;
        PH_NEWD: begin
          n_ph = PH_IDLE;
          if (!desc_nostart_i) begin
            n_state = ST_START;
            n_cmd_v = 1'b1;
            n_code  = CMD_START;
            n_data  = addr_byte(desc_addr_i, desc_rd_i);
          end else begin
            t_st    = desc_rd_i ? ST_READ : ST_WRITE;
            t_pos   = '0;
            do_body = 1'b1;
          end
        end
        default: n_ph = PH_IDLE;
      endcase

      if (do_tail) begin
        n_state = t_st;
        n_pos   = t_pos;
        if (t_pos == desc_len_i) begin
          if (desc_last_i) begin
            n_state = ST_DONE;
            n_cmd_v = 1'b1;
            n_code  = CMD_STOP;
          end else begin
            n_pos   = '0;
            n_dnext = 1'b1;
            n_ph    = PH_WAITD;
          end
        end else begin
          do_body = 1'b1;
        end
      end

      if (do_body) begin
        n_state = t_st;
        n_cmd_v = 1'b1;
        if (t_st == ST_READ) begin
          n_code = (t_pos == last_idx) ? CMD_RD_NACK : CMD_RD_ACK;
          n_pos  = t_pos;
        end else begin
          n_code = CMD_WRITE;
          n_data = wr_data_i;
          n_pop  = 1'b1;
          n_pos  = t_pos + LEN_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_DONE;
      ph_q        <= PH_IDLE;
      pos_q       <= '0;
      busy_q      <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= '0;
      cmd_data_o  <= '0;
      fin_o       <= 1'b0;
      ok_o        <= 1'b0;
      timeout_o   <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
      wr_pop_o    <= 1'b0;
      desc_next_o <= 1'b0;
    end else begin
      state_q     <= n_state;
      ph_q        <= n_ph;
      pos_q       <= n_pos;
      busy_q      <= n_busy;
      cmd_valid_o <= n_cmd_v;
      cmd_code_o  <= n_code;
      cmd_data_o  <= n_data;
      fin_o       <= n_fin;
      ok_o        <= n_ok;
      timeout_o   <= n_to;
      rd_valid_o  <= n_rdv;
      rd_data_o   <= n_rdd;
      wr_pop_o    <= n_pop;
      desc_next_o <= n_dnext;
    end
  end

  assign state_o = state_q;
  assign busy_o  = busy_q;

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int WD_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [WD_W-1:0]  wd_limit_i,
  input  logic [6:0]       desc_addr_i,
  input  logic             desc_rd_i,
  input  logic             desc_nostart_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic             desc_last_i,
  output logic             desc_next_o,
  input  logic [7:0]       wr_data_i,
  output logic             wr_pop_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             cmd_valid_o,
  output logic [7:0]       cmd_code_o,
  output logic [7:0]       cmd_data_o,
  input  logic             irq_i,
  input  logic             stat_nack_i,
  input  logic             stat_arb_i,
  input  logic [7:0]       rx_data_i,
  output logic [2:0]       state_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             ok_o,
  output logic             timeout_o
);

  logic       expire;
  seq_state_e st;

  i2c_seq_core #(.LEN_W(LEN_W)) u_core (
    .clk            (clk),
    .rst            (rst),
    .go_i           (go_i),
    .abort_i        (expire),
    .desc_addr_i    (desc_addr_i),
    .desc_rd_i      (desc_rd_i),
    .desc_nostart_i (desc_nostart_i),
    .desc_len_i     (desc_len_i),
    .desc_last_i    (desc_last_i),
    .desc_next_o    (desc_next_o),
    .wr_data_i      (wr_data_i),
    .wr_pop_o       (wr_pop_o),
    .rd_valid_o     (rd_valid_o),
    .rd_data_o      (rd_data_o),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_code_o     (cmd_code_o),
    .cmd_data_o     (cmd_data_o),
    .irq_i          (irq_i),
    .stat_nack_i    (stat_nack_i),
    .stat_arb_i     (stat_arb_i),
    .rx_data_i      (rx_data_i),
    .state_o        (st),
    .busy_o         (busy_o),
    .fin_o          (fin_o),
    .ok_o           (ok_o),
    .timeout_o      (timeout_o)
  );

  i2c_seq_wdog #(.WD_W(WD_W)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .run_i    (busy_o),
    .limit_i  (wd_limit_i),
    .expire_o (expire)
  );

  assign state_o = st;

endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk
  import i2c_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       go_i,
  input logic [6:0] desc_addr_i,
  input logic       desc_rd_i,
  input logic       cmd_valid_o,
  input logic [7:0] cmd_code_o,
  input logic [7:0] cmd_data_o,
  input logic       irq_i,
  input logic       stat_nack_i,
  input logic       stat_arb_i,
  input logic [2:0] state_o,
  input logic       busy_o,
  input logic       fin_o,
  input logic       ok_o,
  input logic       timeout_o
);

  // R2: an idle go produces a start carrying the address byte
  p_go_start_r2: assert property (@(posedge clk) disable iff (rst)
    (go_i && !busy_o) |=> (cmd_valid_o && cmd_code_o == CMD_START &&
                           cmd_data_o == {$past(desc_addr_i), $past(desc_rd_i)} &&
                           state_o == ST_START));

  // R3: commands are single-cycle pulses
  p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  // R4: read commands only in the read state
  p_read_state_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && (cmd_code_o == CMD_RD_ACK || cmd_code_o == CMD_RD_NACK))
      |-> state_o == ST_READ);

  // R7: NACK after address or write byte leads to stop and error
  p_nack_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_i && busy_o && !stat_arb_i && stat_nack_i && !timeout_o &&
     (state_o == ST_START || state_o == ST_WRITE))
      |=> (timeout_o || (cmd_valid_o && cmd_code_o == CMD_STOP && state_o == ST_ERROR)));

  // R8: arbitration loss leads to stop and error
  p_arb_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_i && busy_o && stat_arb_i && !timeout_o &&
     state_o != ST_DONE && state_o != ST_ERROR)
      |=> (timeout_o || (cmd_valid_o && cmd_code_o == CMD_STOP && state_o == ST_ERROR)));

  // R9: a normal finish comes with an interrupt acknowledge
  p_fin_iack_r9: assert property (@(posedge clk) disable iff (rst)
    (fin_o && !timeout_o) |-> (cmd_valid_o && cmd_code_o == CMD_IACK &&
                               ok_o == (state_o == ST_DONE) && !busy_o));

  // R10: a timeout ends the transfer as a failure
  p_timeout_r10: assert property (@(posedge clk) disable iff (rst)
    (timeout_o && !$past(timeout_o)) |-> (fin_o && !ok_o && !busy_o && !cmd_valid_o));

endmodule

bind i2c_msg_seq i2c_msg_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .go_i        (go_i),
  .desc_addr_i (desc_addr_i),
  .desc_rd_i   (desc_rd_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_code_o  (cmd_code_o),
  .cmd_data_o  (cmd_data_o),
  .irq_i       (irq_i),
  .stat_nack_i (stat_nack_i),
  .stat_arb_i  (stat_arb_i),
  .state_o     (state_o),
  .busy_o      (busy_o),
  .fin_o       (fin_o),
  .ok_o        (ok_o),
  .timeout_o   (timeout_o)
);

// File: tb/i2c_msg_seq_tb.sv
module i2c_msg_seq_tb;

  localparam logic [7:0] C_START = 8'h91, C_STOP = 8'h41, C_WRITE = 8'h11,
                         C_RACK = 8'h21, C_RNACK = 8'h29, C_IACK = 8'h01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        go = 1'b0;
  logic [15:0] wd_limit = 16'd1000;
  logic [7:0]  wr_data = 8'h00;
  logic        irq = 1'b0, nack = 1'b0, arb = 1'b0;
  logic [7:0]  rxd = 8'h00;

  logic [6:0]  d_addr [0:3];
  logic        d_rd   [0:3];
  logic        d_ns   [0:3];
  logic [7:0]  d_len  [0:3];
  int          idx = 0;
  int          nmsg = 1;

  logic        desc_next, wr_pop, rd_valid, cmd_valid, busy, fin, ok, tmo;
  logic [7:0]  rd_data, cmd_code, cmd_data;
  logic [2:0]  state;

  i2c_msg_seq u_dut (
    .clk            (clk),
    .rst            (rst),
    .go_i           (go),
    .wd_limit_i     (wd_limit),
    .desc_addr_i    (d_addr[idx[1:0]]),
    .desc_rd_i      (d_rd[idx[1:0]]),
    .desc_nostart_i (d_ns[idx[1:0]]),
    .desc_len_i     (d_len[idx[1:0]]),
    .desc_last_i    (idx == nmsg - 1),
    .desc_next_o    (desc_next),
    .wr_data_i      (wr_data),
    .wr_pop_o       (wr_pop),
    .rd_valid_o     (rd_valid),
    .rd_data_o      (rd_data),
    .cmd_valid_o    (cmd_valid),
    .cmd_code_o     (cmd_code),
    .cmd_data_o     (cmd_data),
    .irq_i          (irq),
    .stat_nack_i    (nack),
    .stat_arb_i     (arb),
    .rx_data_i      (rxd),
    .state_o        (state),
    .busy_o         (busy),
    .fin_o          (fin),
    .ok_o           (ok),
    .timeout_o      (tmo)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard state
  logic [18:0] exp_q [$];
  logic [7:0]  rd_q  [$];
  logic [7:0]  wq    [$];
  string       cur_req = "R1";
  int          nack_at = -1, arb_at = -1;
  int          ridx = 0, ridx_p = 0, rcnt = 0;
  bit          pend = 0, mute = 0;
  int          resp_delay = 3;
  int          cyc = 0, fin_cnt = 0, fin_cyc = 0, go_cyc = 0;
  bit          ok_seen = 0, to_seen = 0;

  // monitor and controller model
  always @(negedge clk) begin
    logic [18:0] e;
    logic [7:0]  b;
    cyc++;
    irq  = 1'b0;
    nack = 1'b0;
    arb  = 1'b0;
    if (pend) begin
      if (rcnt == 0) begin
        irq  = 1'b1;
        nack = (ridx_p == nack_at);
        arb  = (ridx_p == arb_at);
        rxd  = 8'hC0 + 8'(ridx_p);
        pend = 0;
      end else rcnt--;
    end
    if (!rst && cmd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, {cur_req, " unexpected command"}, cmd_code, 0);
      end else begin
        e = exp_q.pop_front();
        chk(cmd_code == e[15:8], {cur_req, " command code"}, cmd_code, e[15:8]);
        chk(state == e[18:16], {cur_req, " state at command"}, state, e[18:16]);
        if (e[15:8] == C_START || e[15:8] == C_WRITE)
          chk(cmd_data == e[7:0], {cur_req, " command data"}, cmd_data, e[7:0]);
      end
      if (cmd_code != C_IACK && !mute) begin
        pend   = 1;
        rcnt   = resp_delay;
        ridx_p = ridx;
        ridx++;
      end
    end
    if (desc_next) idx++;
    if (wr_pop && wq.size() > 0) b = wq.pop_front();
    wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
    if (rd_valid) begin
      if (rd_q.size() == 0) chk(0, {cur_req, " R4 unexpected read byte"}, rd_data, 0);
      else begin
        b = rd_q.pop_front();
        chk(rd_data == b, {cur_req, " R4 read byte"}, rd_data, b);
      end
    end
    if (fin) begin
      fin_cnt++;
      ok_seen = ok;
      to_seen = tmo;
      fin_cyc = cyc;
    end
  end

  task automatic set_desc(input int i, input logic [6:0] a, input bit rd, input bit ns,
                          input int len);
    d_addr[i] = a;
    d_rd[i]   = rd;
    d_ns[i]   = ns;
    d_len[i]  = 8'(len);
  endtask

  task automatic push(input logic [2:0] st, input logic [7:0] code, input logic [7:0] data);
    exp_q.push_back({st, code, data});
  endtask

  task automatic run_list(input string req, input int nack_i, input int arb_i,
                          input bit exp_ok, input bit exp_to, input bit extra_go);
    int f0;
    cur_req = req;
    nack_at = nack_i;
    arb_at  = arb_i;
    ridx    = 0;
    idx     = 0;
    wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
    f0      = fin_cnt;
    @(negedge clk);
    go     = 1'b1;
    go_cyc = cyc;
    @(negedge clk);
    go = 1'b0;
    if (extra_go) begin
      repeat (2) @(negedge clk);
      go = 1'b1;  // R2: ignored while busy
      @(negedge clk);
      go = 1'b0;
    end
    for (int n = 0; n < 8000 && fin_cnt == f0; n++) @(negedge clk);
    chk(fin_cnt != f0, {req, " R9 finish seen"}, fin_cnt - f0, 1);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, {req, " all commands issued"}, exp_q.size(), 0);
    chk(rd_q.size() == 0, {req, " R4 all read bytes"}, rd_q.size(), 0);
    chk(ok_seen == exp_ok, {req, " R9 ok flag"}, ok_seen, exp_ok);
    chk(to_seen == exp_to, {req, " R10 timeout flag"}, to_seen, exp_to);
    chk(state == (exp_ok ? 3'd0 : 3'd4), {req, " final state"}, state, exp_ok ? 0 : 4);
    chk(busy == 1'b0, {req, " busy cleared"}, busy, 0);
    exp_q.delete();
    rd_q.delete();
    wq.delete();
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) set_desc(i, 7'h00, 1'b0, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state == 3'd0, "R1 state", state, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
    chk(fin == 1'b0, "R1 fin", fin, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3 R6 two-byte write, with a second go while busy (R2)
    nmsg = 1; set_desc(0, 7'h50, 0, 0, 2);
    wq.push_back(8'h5A); wq.push_back(8'hA5);
    push(1, C_START, 8'hA0); push(2, C_WRITE, 8'h5A); push(2, C_WRITE, 8'hA5);
    push(0, C_STOP, 0); push(0, C_IACK, 0);
    run_list("R3 write", -1, -1, 1, 0, 1);

    // R4 three-byte read
    nmsg = 1; set_desc(0, 7'h21, 1, 0, 3);
    push(1, C_START, 8'h43); push(3, C_RACK, 0); push(3, C_RACK, 0); push(3, C_RNACK, 0);
    push(0, C_STOP, 0); push(0, C_IACK, 0);
    rd_q.push_back(8'hC1); rd_q.push_back(8'hC2); rd_q.push_back(8'hC3);
    run_list("R4 read3", -1, -1, 1, 0, 0);

    // R5 write then repeated start read
    nmsg = 2; set_desc(0, 7'h3C, 0, 0, 1); set_desc(1, 7'h3C, 1, 0, 2);
    wq.push_back(8'h10);
    push(1, C_START, 8'h78); push(2, C_WRITE, 8'h10); push(1, C_START, 8'h79);
    push(3, C_RACK, 0); push(3, C_RNACK, 0); push(0, C_STOP, 0); push(0, C_IACK, 0);
    rd_q.push_back(8'hC3); rd_q.push_back(8'hC4);
    run_list("R5 restart", -1, -1, 1, 0, 0);

    // R5 no-start write continuation
    nmsg = 2; set_desc(0, 7'h11, 0, 0, 1); set_desc(1, 7'h11, 0, 1, 1);
    wq.push_back(8'h33); wq.push_back(8'h44);
    push(1, C_START, 8'h22); push(2, C_WRITE, 8'h33); push(2, C_WRITE, 8'h44);
    push(0, C_STOP, 0); push(0, C_IACK, 0);
    run_list("R5 nostart write", -1, -1, 1, 0, 0);

    // R5 no-start read after a write
    nmsg = 2; set_desc(0, 7'h0A, 0, 0, 1); set_desc(1, 7'h0A, 1, 1, 2);
    wq.push_back(8'h99);
    push(1, C_START, 8'h14); push(2, C_WRITE, 8'h99); push(3, C_RACK, 0);
    push(3, C_RNACK, 0); push(0, C_STOP, 0); push(0, C_IACK, 0);
    rd_q.push_back(8'hC2); rd_q.push_back(8'hC3);
    run_list("R5 nostart read", -1, -1, 1, 0, 0);

    // R7 address NACK
    nmsg = 1; set_desc(0, 7'h50, 0, 0, 2);
    wq.push_back(8'h01); wq.push_back(8'h02);
    push(1, C_START, 8'hA0); push(4, C_STOP, 0); push(4, C_IACK, 0);
    run_list("R7 addr nack", 0, -1, 0, 0, 0);

    // R7 data NACK
    nmsg = 1; set_desc(0, 7'h50, 0, 0, 2);
    wq.push_back(8'h01); wq.push_back(8'h02);
    push(1, C_START, 8'hA0); push(2, C_WRITE, 8'h01); push(4, C_STOP, 0); push(4, C_IACK, 0);
    run_list("R7 data nack", 1, -1, 0, 0, 0);

    // R8 arbitration lost during read, no byte delivered
    nmsg = 1; set_desc(0, 7'h21, 1, 0, 2);
    push(1, C_START, 8'h43); push(3, C_RACK, 0); push(4, C_STOP, 0); push(4, C_IACK, 0);
    run_list("R8 arb lost", 1, 1, 0, 0, 0);

    // R6 zero-length write
    nmsg = 1; set_desc(0, 7'h2A, 0, 0, 0);
    push(1, C_START, 8'h54); push(0, C_STOP, 0); push(0, C_IACK, 0);
    run_list("R6 zero length", -1, -1, 1, 0, 0);

    // R4 single-byte read gets NACK at once
    nmsg = 1; set_desc(0, 7'h7F, 1, 0, 1);
    push(1, C_START, 8'hFF); push(3, C_RNACK, 0); push(0, C_STOP, 0); push(0, C_IACK, 0);
    rd_q.push_back(8'hC1);
    run_list("R4 read1", -1, -1, 1, 0, 0);

    // R10 watchdog: controller never answers
    mute = 1; wd_limit = 16'd20;
    nmsg = 1; set_desc(0, 7'h50, 0, 0, 1);
    wq.push_back(8'h66);
    push(1, C_START, 8'hA0);
    run_list("R10 timeout", -1, -1, 0, 1, 0);
    chk((fin_cyc - go_cyc) >= 20 && (fin_cyc - go_cyc) <= 25, "R10 timeout window",
        fin_cyc - go_cyc, 22);
    mute = 0;

    // R10 limit zero disables watchdog on a slow controller
    wd_limit = 16'd0; resp_delay = 300;
    nmsg = 1; set_desc(0, 7'h50, 0, 0, 1);
    wq.push_back(8'h77);
    push(1, C_START, 8'hA0); push(2, C_WRITE, 8'h77); push(0, C_STOP, 0); push(0, C_IACK, 0);
    run_list("R10 disabled", -1, -1, 1, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule